// File: doc/BRIEF.md
# Write-Only Register Shadow Readback Unit

This unit keeps shadow copies of setup registers that software can write but never read back: the initialization and operation control words of a cascaded pair of interrupt controllers (a master at base 20h and a slave at base A0h), and the command, request and per-channel mode registers of the upper four-channel DMA group. It snoops the I/O write bus. Every write to a tracked address is stored at the clock edge that follows the write strobe. To fill the interrupt controller shadows correctly, it follows each controller's initialization sequence. The sequence opens with the first word (bit 4 set at the base address). The second, third and fourth words then follow at base+1. The third word is skipped when bit 1 of the first word selects single mode. The fourth word is skipped when bit 0 of the first word is clear.

Software that saves and restores system state sets the alternate access mode input and then reads two fixed addresses repeatedly. Each read of 20h returns the next of twelve interrupt controller shadows. Each read of D0h returns the next of six DMA shadows. Reserved bits are patched to fixed values on the way out. When alternate mode is off, reads of those addresses are flagged for the normal read path, and the sequence position is held.

Each controller tracker is a four-state machine. INIT_IDLE is the operating state. In it, base+1 writes are the interrupt mask, and base writes with bit 4 clear are the second or third operation word, told apart by bit 3. A first-word write in any state enters INIT_WAIT_W2. From INIT_WAIT_W2, a base+1 write goes to INIT_WAIT_W3 in cascade mode, to INIT_WAIT_W4 in single mode when the fourth word is requested, and to INIT_IDLE otherwise. From INIT_WAIT_W3, a base+1 write goes to INIT_WAIT_W4 when the fourth word is requested, and to INIT_IDLE otherwise. From INIT_WAIT_W4, a base+1 write returns to INIT_IDLE.

Top module: `wo_shadow_rb`

## Requirements
- R1: With alt_mode high, successive reads of 20h return these entries in order: master ICW2, ICW3, ICW4, OCW1, OCW2, OCW3, then the same six for the slave.
- R2: With alt_mode high, successive reads of D0h return these entries in order: the command register, the request register, then the mode registers of channels 4, 5, 6 and 7.
- R3: A returned DMA mode entry carries the channel index within the group in bits 1:0 (0 for channel 4 up to 3 for channel 7), whatever was written there. Bits 7:2 are the written bits of that channel's last mode write. A mode write (address D6h) is filed under the channel named by its own bits 1:0.
- R4: A returned DMA request entry has bits 5, 3, 1 and 0 at 0. Bits 7, 6, 4 and 2 are as last written to D2h. The command entry is the last byte written to D0h.
- R5: On readback, ICW2 returns bits 2:0 as 0, and ICW4 returns only bits 4 and 1 as written, with all other bits at 0. ICW3 and OCW1 return exactly as written.
- R6: On readback, OCW2 bits 4:3 return 00. OCW3 returns bit 7 as 0, bit 5 as a copy of its bit 6, and bits 4:3 as 01, with the other bits as written.
- R7: The two addresses keep separate positions. A position goes back to the first entry on the first cycle with alt_mode high after it was low, and wraps to the first entry after its last entry.
- R8: With alt_mode low, a read of 20h or D0h raises pass_through, leaves rd_hit low and rd_data at 0, and does not move either position.
- R9: Initialization words are filed by the state machine above. In single mode no ICW3 is taken. Without a fourth-word request no ICW4 is taken. Writes to base+1 in INIT_IDLE are taken as OCW1.
- R10: Reset clears every shadow to 0 and both positions to their first entry. A write becomes visible on readback from the cycle after its strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_rd | input | 1 | I/O read strobe, one cycle per read |
| io_addr | input | ADDR_W | I/O address |
| io_wdata | input | 8 | Write data |
| alt_mode | input | 1 | Alternate access mode enable |
| rd_data | output | 8 | Shadow value for a claimed read, else 0 |
| rd_hit | output | 1 | Read of 20h or D0h is answered from the shadows |
| pass_through | output | 1 | Read of 20h or D0h goes to the normal path |

## Verification
The checker watches several properties on every cycle. It confirms that the positions stay in range and hold still while alt_mode is low. It confirms that each position wraps after its last entry and returns to the first entry when alt_mode rises. It confirms that the reserved-bit patterns of every returned ICW2, ICW4, OCW2, OCW3, DMA request and DMA mode entry are correct, and that the command shadow changes only after a write to it. Other behaviour can only be shown by the bench's scenarios against its reference model. These are the order of the entries, the routing of words through single-mode and no-ICW4 initialization, the OCW2/OCW3 split, filing mode writes by channel, and the rule that a write shows one cycle later.

// File: rtl/wsr_pkg.sv
package wsr_pkg;

    typedef enum logic [1:0] {
        INIT_IDLE    = 2'd0,
        INIT_WAIT_W2 = 2'd1,
        INIT_WAIT_W3 = 2'd2,
        INIT_WAIT_W4 = 2'd3
    } init_state_e;

    typedef struct packed {
        logic [7:0] w2;
        logic [7:0] w3;
        logic [7:0] w4;
        logic [7:0] o1;
        logic [7:0] o2;
        logic [7:0] o3;
    } pic_shadow_t;

    localparam int PIC_WORDS = 6;
    localparam int PIC_CTRLS = 2;
    localparam int DMA_CHANS = 4;

    function automatic logic [7:0] pic_patch(input logic [2:0] slot, input pic_shadow_t s);
        logic [7:0] v;
        unique case (slot)
            3'd0:    v = {s.w2[7:3], 3'b000};
            3'd1:    v = s.w3;
            3'd2:    v = {3'b000, s.w4[4], 2'b00, s.w4[1], 1'b0};
            3'd3:    v = s.o1;
            3'd4:    v = {s.o2[7:5], 2'b00, s.o2[2:0]};
            3'd5:    v = {1'b0, s.o3[6], s.o3[6], 2'b01, s.o3[2:0]};
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/wsr_pic_track.sv
module wsr_pic_track
    import wsr_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter logic [15:0] BASE   = 16'h0020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output pic_shadow_t       shadow,
    output init_state_e       state
);

    localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(BASE + 16'd1);

    init_state_e state_q, state_d;
    logic        single_q;
    logic        want_w4_q;
    pic_shadow_t sh_q;

    logic hit_cmd, hit_dat, is_w1;

    assign hit_cmd = wr_en && (addr == CMD_A);
    assign hit_dat = wr_en && (addr == DAT_A);
    assign is_w1   = hit_cmd && wdata[4];

    always_comb begin
        state_d = state_q;
        if (is_w1) begin
            state_d = INIT_WAIT_W2;
        end else if (hit_dat) begin
            unique case (state_q)
                INIT_IDLE:    state_d = INIT_IDLE;
                INIT_WAIT_W2: state_d = !single_q ? INIT_WAIT_W3 :
                                        (want_w4_q ? INIT_WAIT_W4 : INIT_IDLE);
                INIT_WAIT_W3: state_d = want_w4_q ? INIT_WAIT_W4 : INIT_IDLE;
                INIT_WAIT_W4: state_d = INIT_IDLE;
                default:      state_d = INIT_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= INIT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q      <= '0;
            single_q  <= 1'b0;
            want_w4_q <= 1'b0;
        end else begin
            if (is_w1) begin
                single_q  <= wdata[1];
                want_w4_q <= wdata[0];
            end else if (hit_cmd) begin
                if (wdata[3]) sh_q.o3 <= wdata;
                else          sh_q.o2 <= wdata;
            end
            if (hit_dat) begin
                unique case (state_q)
                    INIT_WAIT_W2: sh_q.w2 <= wdata;
                    INIT_WAIT_W3: sh_q.w3 <= wdata;
                    INIT_WAIT_W4: sh_q.w4 <= wdata;
                    INIT_IDLE:    sh_q.o1 <= wdata;
                    default:      sh_q.o1 <= wdata;
                endcase
            end
        end
    end

    assign shadow = sh_q;
    assign state  = state_q;

endmodule

// File: rtl/wsr_dma_track.sv
module wsr_dma_track #(
    parameter int          ADDR_W    = 16,
    parameter int          CHANS     = 4,
    parameter logic [15:0] CMD_ADDR  = 16'h00D0,
    parameter logic [15:0] REQ_ADDR  = 16'h00D2,
    parameter logic [15:0] MODE_ADDR = 16'h00D6,
    parameter int          CW        = $clog2(CHANS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [7:0]             wdata,
    output logic [7:0]             cmd,
    output logic [7:0]             req,
    output logic [CHANS-1:0][7:0]  mode
);

    logic [7:0]            cmd_q, req_q;
    logic [CHANS-1:0][7:0] mode_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
            req_q <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(CMD_ADDR)) cmd_q <= wdata;
            if (addr == ADDR_W'(REQ_ADDR)) req_q <= wdata;
        end
    end

    for (genvar ch = 0; ch < CHANS; ch++) begin : g_mode
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_q[ch] <= '0;
            end else if (wr_en && addr == ADDR_W'(MODE_ADDR) && wdata[CW-1:0] == CW'(ch)) begin
                mode_q[ch] <= wdata;
            end
        end
    end

    assign cmd  = cmd_q;
    assign req  = req_q;
    assign mode = mode_q;

endmodule

// File: rtl/wsr_rd_seq.sv
module wsr_rd_seq #(
    parameter int LEN = 12,
    parameter int IW  = $clog2(LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alt_entry,
    input  logic          rd_en,
    output logic [IW-1:0] idx
);

    localparam logic [IW-1:0] LAST = IW'(LEN - 1);

    logic [IW-1:0] cnt_q;

    assign idx = alt_entry ? '0 : cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (rd_en) begin
            cnt_q <= (idx == LAST) ? '0 : idx + 1'b1;
        end else if (alt_entry) begin
            cnt_q <= '0;
        end
    end

endmodule

// File: rtl/wo_shadow_rb.sv
module wo_shadow_rb
    import wsr_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter logic [15:0] MASTER_BASE = 16'h0020,
    parameter logic [15:0] SLAVE_BASE  = 16'h00A0,
    parameter logic [15:0] DMA_CMD_A   = 16'h00D0,
    parameter logic [15:0] DMA_REQ_A   = 16'h00D2,
    parameter logic [15:0] DMA_MODE_A  = 16'h00D6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              alt_mode,
    output logic [7:0]        rd_data,
    output logic              rd_hit,
    output logic              pass_through
);

    localparam int PIC_LEN = PIC_WORDS * PIC_CTRLS;
    localparam int DMA_LEN = 2 + DMA_CHANS;
    localparam int PIW     = $clog2(PIC_LEN);
    localparam int DIW     = $clog2(DMA_LEN);
    localparam int CW      = $clog2(DMA_CHANS);
    localparam logic [ADDR_W-1:0] PIC_RD_A = ADDR_W'(MASTER_BASE);
    localparam logic [ADDR_W-1:0] DMA_RD_A = ADDR_W'(DMA_CMD_A);

    pic_shadow_t pic_sh [PIC_CTRLS];
    init_state_e pic_st [PIC_CTRLS];

    for (genvar gi = 0; gi < PIC_CTRLS; gi++) begin : g_pic
        localparam logic [15:0] B = (gi == 0) ? MASTER_BASE : SLAVE_BASE;
        wsr_pic_track #(.ADDR_W(ADDR_W), .BASE(B)) u_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (io_wr),
            .addr   (io_addr),
            .wdata  (io_wdata),
            .shadow (pic_sh[gi]),
            .state  (pic_st[gi])
        );
    end

    logic [7:0]                dma_cmd_sh, dma_req_sh;
    logic [DMA_CHANS-1:0][7:0] dma_mode_sh;

    wsr_dma_track #(
        .ADDR_W(ADDR_W), .CHANS(DMA_CHANS),
        .CMD_ADDR(DMA_CMD_A), .REQ_ADDR(DMA_REQ_A), .MODE_ADDR(DMA_MODE_A)
    ) u_dma (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (io_wr),
        .addr  (io_addr),
        .wdata (io_wdata),
        .cmd   (dma_cmd_sh),
        .req   (dma_req_sh),
        .mode  (dma_mode_sh)
    );

    logic alt_q, alt_entry;
    logic sel_pic, sel_dma, pic_rd, dma_rd;
    logic [PIW-1:0] pic_idx;
    logic [DIW-1:0] dma_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) alt_q <= 1'b0;
        else        alt_q <= alt_mode;
    end

    assign alt_entry = alt_mode && !alt_q;
    assign sel_pic   = io_rd && (io_addr == PIC_RD_A);
    assign sel_dma   = io_rd && (io_addr == DMA_RD_A);
    assign pic_rd    = alt_mode && sel_pic;
    assign dma_rd    = alt_mode && sel_dma;

    wsr_rd_seq #(.LEN(PIC_LEN)) u_pic_seq (
        .clk(clk), .rst_n(rst_n), .alt_entry(alt_entry), .rd_en(pic_rd), .idx(pic_idx)
    );

    wsr_rd_seq #(.LEN(DMA_LEN)) u_dma_seq (
        .clk(clk), .rst_n(rst_n), .alt_entry(alt_entry), .rd_en(dma_rd), .idx(dma_idx)
    );

    logic [7:0] pic_val, dma_val;
    logic       pic_slave;
    logic [2:0] pic_slot;

    always_comb begin
        pic_slave = (pic_idx >= PIW'(PIC_WORDS));
        pic_slot  = pic_slave ? 3'(pic_idx - PIW'(PIC_WORDS)) : 3'(pic_idx);
        pic_val   = pic_patch(pic_slot, pic_slave ? pic_sh[1] : pic_sh[0]);
    end

    always_comb begin
        dma_val = 8'h00;
        if (dma_idx == DIW'(0)) begin
            dma_val = dma_cmd_sh;
        end else if (dma_idx == DIW'(1)) begin
            dma_val = dma_req_sh & 8'hD4;
        end else begin
            for (int c = 0; c < DMA_CHANS; c++) begin
                if (dma_idx == DIW'(c + 2)) dma_val = {dma_mode_sh[c][7:CW], CW'(c)};
            end
        end
    end

    assign rd_hit       = pic_rd || dma_rd;
    assign pass_through = !alt_mode && (sel_pic || sel_dma);
    assign rd_data      = pic_rd ? pic_val : (dma_rd ? dma_val : 8'h00);

endmodule

// File: rtl/wsr_checker.sv
module wsr_checker #(
    parameter int ADDR_W = 16,
    parameter int PIW    = 4,
    parameter int DIW    = 3,
    parameter logic [15:0] PIC_A = 16'h0020,
    parameter logic [15:0] DMA_A = 16'h00D0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_wr,
    input logic              io_rd,
    input logic [ADDR_W-1:0] io_addr,
    input logic              alt_mode,
    input logic [7:0]        rd_data,
    input logic              rd_hit,
    input logic              pass_through,
    input logic [PIW-1:0]    pic_idx,
    input logic [DIW-1:0]    dma_idx,
    input logic [7:0]        dma_cmd_sh
);

    logic pic_read, dma_read;
    assign pic_read = rd_hit && io_addr == ADDR_W'(PIC_A);
    assign dma_read = rd_hit && io_addr == DMA_A[ADDR_W-1:0];

    a_r7_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        pic_idx < PIW'(12) && dma_idx < DIW'(6));

    a_r7_pic_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (pic_read && pic_idx == PIW'(11)) |=> pic_idx == '0);

    a_r7_dma_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_read && dma_idx == DIW'(5)) |=> dma_idx == '0);

    a_r7_entry_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alt_mode) |-> (pic_idx == '0 && dma_idx == '0));

    a_r8_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        !alt_mode |=> (alt_mode || ($stable(pic_idx) && $stable(dma_idx))));

    a_r8_pass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pass_through |-> (!rd_hit && rd_data == 8'h00 && !alt_mode && io_rd));

    a_r3_mode_chan: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_read && dma_idx >= DIW'(2)) |-> rd_data[1:0] == 2'(dma_idx - DIW'(2)));

    a_r4_req_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_read && dma_idx == DIW'(1)) |-> (rd_data & 8'h2B) == 8'h00);

    a_r5_icw2: assert property (@(posedge clk) disable iff (!rst_n)
        (pic_read && (pic_idx == PIW'(0) || pic_idx == PIW'(6))) |-> rd_data[2:0] == 3'b000);

    a_r5_icw4: assert property (@(posedge clk) disable iff (!rst_n)
        (pic_read && (pic_idx == PIW'(2) || pic_idx == PIW'(8))) |-> (rd_data & 8'hED) == 8'h00);

    a_r6_ocw2: assert property (@(posedge clk) disable iff (!rst_n)
        (pic_read && (pic_idx == PIW'(4) || pic_idx == PIW'(10))) |-> rd_data[4:3] == 2'b00);

    a_r6_ocw3: assert property (@(posedge clk) disable iff (!rst_n)
        (pic_read && (pic_idx == PIW'(5) || pic_idx == PIW'(11))) |->
        (!rd_data[7] && rd_data[5] == rd_data[6] && rd_data[4:3] == 2'b01));

    a_r10_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_addr == DMA_A[ADDR_W-1:0]) |=> $stable(dma_cmd_sh));

endmodule

bind wo_shadow_rb wsr_checker #(
    .ADDR_W(ADDR_W), .PIW(PIW), .DIW(DIW), .PIC_A(MASTER_BASE), .DMA_A(DMA_CMD_A)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .io_wr        (io_wr),
    .io_rd        (io_rd),
    .io_addr      (io_addr),
    .alt_mode     (alt_mode),
    .rd_data      (rd_data),
    .rd_hit       (rd_hit),
    .pass_through (pass_through),
    .pic_idx      (pic_idx),
    .dma_idx      (dma_idx),
    .dma_cmd_sh   (dma_cmd_sh)
);

// File: tb/tb_wo_shadow_rb.sv
module tb_wo_shadow_rb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0, io_rd = 1'b0, alt_mode = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  rd_data;
    logic        rd_hit, pass_through;

    int n_cmp = 0, n_bad = 0;

    always #10 clk = ~clk;

    wo_shadow_rb dut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .io_wdata(io_wdata), .alt_mode(alt_mode), .rd_data(rd_data), .rd_hit(rd_hit),
        .pass_through(pass_through)
    );

    // Reference model
    byte unsigned m_pic [2][6];
    int           m_phase [2];
    bit           m_single [2], m_four [2];
    byte unsigned m_cmd, m_req;
    byte unsigned m_mode [4];
    int           m_pos_p, m_pos_d;
    bit           m_alt_prev;

    function automatic byte unsigned pic_out(int k);
        int c = k / 6;
        int r = k % 6;
        byte unsigned v = m_pic[c][r];
        case (r)
            0: return v & 8'hF8;
            2: return v & 8'h12;
            4: return v & 8'hE7;
            5: return (v & 8'h47) | 8'h08 | ((v & 8'h40) >> 1);
            default: return v;
        endcase
    endfunction

    function automatic byte unsigned dma_out(int k);
        if (k == 0) return m_cmd;
        if (k == 1) return m_req & 8'hD4;
        return (m_mode[k-2] & 8'hFC) | byte'(k - 2);
    endfunction

    task automatic model_write(int c, int base, logic [15:0] a, byte unsigned d);
        if (a == 16'(base)) begin
            if (d[4]) begin
                m_phase[c] = 1; m_single[c] = d[1]; m_four[c] = d[0];
            end else if (d[3]) m_pic[c][5] = d;
            else               m_pic[c][4] = d;
        end else if (a == 16'(base + 1)) begin
            case (m_phase[c])
                1: begin m_pic[c][0] = d; m_phase[c] = !m_single[c] ? 2 : (m_four[c] ? 3 : 0); end
                2: begin m_pic[c][1] = d; m_phase[c] = m_four[c] ? 3 : 0; end
                3: begin m_pic[c][2] = d; m_phase[c] = 0; end
                default: m_pic[c][3] = d;
            endcase
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_pic[c, r]) m_pic[c][r] = 0;
            foreach (m_phase[c]) begin m_phase[c] = 0; m_single[c] = 0; m_four[c] = 0; end
            foreach (m_mode[c]) m_mode[c] = 0;
            m_cmd = 0; m_req = 0; m_pos_p = 0; m_pos_d = 0; m_alt_prev = 0;
        end else begin
            if (alt_mode && !m_alt_prev) begin m_pos_p = 0; m_pos_d = 0; end
            if (alt_mode && io_rd && io_addr == 16'h20) m_pos_p = (m_pos_p + 1) % 12;
            if (alt_mode && io_rd && io_addr == 16'hD0) m_pos_d = (m_pos_d + 1) % 6;
            m_alt_prev = alt_mode;
            if (io_wr) begin
                model_write(0, 16'h20, io_addr, io_wdata);
                model_write(1, 16'hA0, io_addr, io_wdata);
                if (io_addr == 16'hD0) m_cmd = io_wdata;
                if (io_addr == 16'hD2) m_req = io_wdata;
                if (io_addr == 16'hD6) m_mode[io_wdata[1:0]] = io_wdata;
            end
        end
    end

    task automatic compare(string tag);
        bit eh, ep;
        byte unsigned ed;
        int pp, pd;
        bit entry = alt_mode && !m_alt_prev && rst_n;
        pp = entry ? 0 : m_pos_p;
        pd = entry ? 0 : m_pos_d;
        eh = 0; ep = 0; ed = 0;
        if (io_rd && (io_addr == 16'h20 || io_addr == 16'hD0)) begin
            if (alt_mode) begin
                eh = 1;
                ed = (io_addr == 16'h20) ? pic_out(pp) : dma_out(pd);
            end else ep = 1;
        end
        n_cmp++;
        if (rd_hit !== eh || pass_through !== ep || rd_data !== ed) begin
            n_bad++;
            $display("FAIL %s: hit/pass/data actual %b/%b/%02h expected %b/%b/%02h",
                     tag, rd_hit, pass_through, rd_data, eh, ep, ed);
        end
    endtask

    task automatic step(bit w, bit r, logic [15:0] a, logic [7:0] d, string tag);
        @(negedge clk);
        io_wr = w; io_rd = r; io_addr = a; io_wdata = d;
        #2 compare(tag);
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d, string tag);
        step(1, 0, a, d, tag);
    endtask

    task automatic rd(logic [15:0] a, string tag);
        step(0, 1, a, 8'h00, tag);
    endtask

    initial begin
        #4000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) step(0, 0, 16'h0, 8'h0, "R10 during reset");
        @(negedge clk); rst_n = 1'b1;
        // R10 reset state visible through readback
        alt_mode = 1'b1;
        for (int i = 0; i < 3; i++) rd(16'h20, "R10 cleared pic shadow");
        rd(16'hD0, "R10 cleared dma shadow");
        alt_mode = 1'b0;
        step(0, 0, 16'h0, 8'h0, "R8 idle");

        // R9 cascade init with ICW4 on both controllers
        wr(16'h20, 8'h11, "R9 master ICW1");
        wr(16'h21, 8'h0F, "R9 master ICW2");
        wr(16'h21, 8'h04, "R9 master ICW3");
        wr(16'h21, 8'hFF, "R9 master ICW4");
        wr(16'hA0, 8'h11, "R9 slave ICW1");
        wr(16'hA1, 8'h77, "R9 slave ICW2");
        wr(16'hA1, 8'h02, "R9 slave ICW3");
        wr(16'hA1, 8'h1D, "R9 slave ICW4");
        wr(16'h21, 8'hB5, "R9 master OCW1");
        wr(16'hA1, 8'h3C, "R9 slave OCW1");
        wr(16'h20, 8'hE7, "R6 master OCW2");
        wr(16'h20, 8'h4A, "R6 master OCW3");
        wr(16'hA0, 8'h67, "R6 slave OCW2");
        wr(16'hA0, 8'h8B, "R6 slave OCW3");
        // DMA group
        wr(16'hD0, 8'hA5, "R4 command");
        wr(16'hD2, 8'hFF, "R4 request");
        wr(16'hD6, 8'hC4, "R3 mode ch4");
        wr(16'hD6, 8'h5D, "R3 mode ch5");
        wr(16'hD6, 8'h9A, "R3 mode ch6");
        wr(16'hD6, 8'h2F, "R3 mode ch7");

        // R8 alt off: pass through, no position movement
        rd(16'h20, "R8 pass 20h");
        rd(16'hD0, "R8 pass D0h");
        rd(16'h20, "R8 pass 20h again");

        // R1 R5 R6 full walk plus wrap (R7)
        alt_mode = 1'b1;
        for (int i = 0; i < 14; i++) rd(16'h20, "R1 pic sequence");
        // R2 R3 R4 with interleave (R7 separate positions)
        for (int i = 0; i < 4; i++) begin
            rd(16'hD0, "R2 dma sequence");
            rd(16'h20, "R7 interleaved pic");
        end
        for (int i = 0; i < 4; i++) rd(16'hD0, "R2 dma wrap");

        // R10 write during alt mode shows next cycle
        wr(16'hD0, 8'h3C, "R10 cmd write in alt");
        step(0, 0, 16'h0, 8'h0, "R10 gap");
        for (int i = 0; i < 6; i++) rd(16'hD0, "R10 new command visible");

        // R7 re-entry resets mid-sequence position
        rd(16'h20, "R7 advance");
        alt_mode = 1'b0;
        rd(16'h20, "R8 hold while off");
        alt_mode = 1'b1;
        rd(16'h20, "R7 re-entry first entry");
        rd(16'hD0, "R7 re-entry dma first");

        // R9 single mode with ICW4, then without ICW4 / cascade without ICW4
        alt_mode = 1'b0;
        wr(16'hA0, 8'h13, "R9 slave single ICW1");
        wr(16'hA1, 8'h88, "R9 slave ICW2 single");
        wr(16'hA1, 8'h13, "R9 slave ICW4 single");
        wr(16'hA1, 8'hE1, "R9 slave OCW1 after single");
        wr(16'h20, 8'h10, "R9 master no-ICW4 ICW1");
        wr(16'h21, 8'h50, "R9 master ICW2");
        wr(16'h21, 8'h06, "R9 master ICW3");
        wr(16'h21, 8'h99, "R9 master OCW1 no ICW4");
        wr(16'hA0, 8'h12, "R9 slave single no ICW4");
        wr(16'hA1, 8'hF8, "R9 slave ICW2 only");
        wr(16'hA1, 8'h42, "R9 slave OCW1 at once");
        wr(16'h20, 8'h28, "R6 OCW3 bit6 clear");
        alt_mode = 1'b1;
        for (int i = 0; i < 12; i++) rd(16'h20, "R9 pic sequence after reinit");
        for (int i = 0; i < 6; i++) rd(16'hD0, "R3 dma sequence");
        alt_mode = 1'b0;
        step(0, 0, 16'h0, 8'h0, "R8 end idle");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule